// File: doc/BRIEF.md
# Top-K Feature Filter

This block sits on a stream of detected image features. Each feature carries a corner score, pixel coordinates and a 256-bit descriptor. The block keeps the best `CAPACITY` features while the stream is still arriving. It does this with a min-heap held in on-chip storage, so the weakest kept feature is always at the root. Once the heap is full, a new arrival only has to be compared with that root. A stronger arrival overwrites the root and sinks to its place. A weaker or equal arrival is thrown away.

Features arrive on a valid/ready port, and the final feature of a frame is marked with a last flag. After that final feature has been handled, the block streams every kept feature out on a second valid/ready port, in heap-array order. It then empties itself and accepts the next frame. A count port always shows how many features are held.

Top module: `topk_feature_filter`

## Requirements
- R1: After reset, kept_count_o is 0, out_valid_o is 0 and in_ready_o is 1.
- R2: While fewer than CAPACITY features are held, every accepted arrival is kept, and kept_count_o rises by exactly one in the cycle after the acceptance.
- R3: When the heap is full, an arrival whose score is strictly greater than the lowest kept score replaces that lowest entry. kept_count_o stays at CAPACITY.
- R4: When the heap is full, an arrival whose score is less than or equal to the lowest kept score is dropped. The kept set and kept_count_o are unchanged, and in_ready_o stays 1 in the next cycle.
- R5: in_ready_o is 0 while an insertion or replacement is being sifted into place, and during the output drain. An arrival that is kept therefore holds in_ready_o at 0 in the cycle after its acceptance.
- R6: After the arrival flagged by in_last_i has been handled (kept or dropped), the block presents exactly kept_count_o features on the output port. Each feature has the score, x, y and descriptor it arrived with. While out_valid_o is 1 and out_ready_i is 0, the output fields and out_valid_o hold steady.
- R7: The drain order is heap-array order, index 0 first. The first feature out has the lowest kept score. The feature at output position i (i > 0) has a score no lower than the feature at position (i-1)/2.
- R8: In the cycle after the final output handshake, out_valid_o is 0, kept_count_o is 0 and in_ready_o is 1, ready for a new stream.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Arrival feature valid |
| in_ready_o | output | 1 | Block can take an arrival |
| in_last_i | input | 1 | Arrival is the final feature of the stream |
| in_score_i | input | SCORE_W | Corner score, higher is better |
| in_x_i | input | COORD_W | Column of the feature |
| in_y_i | input | COORD_W | Row of the feature |
| in_desc_i | input | DESC_W | Binary descriptor |
| out_valid_o | output | 1 | Drained feature valid |
| out_ready_i | input | 1 | Consumer takes the drained feature |
| out_score_o | output | SCORE_W | Drained score |
| out_x_o | output | COORD_W | Drained column |
| out_y_o | output | COORD_W | Drained row |
| out_desc_o | output | DESC_W | Drained descriptor |
| kept_count_o | output | $clog2(CAPACITY+1) | Number of features held |

## Verification
The hardest case to reach is the full heap receiving an arrival that ties exactly with the weakest kept score. In that case the tie-break decides whether the heap is rewritten. The bench builds the block with a capacity of eight and fills it with known distinct scores. It then offers an exact tie carrying a different payload, followed by a lower score, a replacement, and a last-flagged tie against the new minimum. The drained payloads show whether any tied arrival slipped in. Out-of-order sift-downs are exercised by a longer stream in scrambled order, and output backpressure is exercised by a periodic stall of out_ready_i.

// File: rtl/topk_pkg.sv
package topk_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_UP    = 2'd1,
    ST_DOWN  = 2'd2,
    ST_DRAIN = 2'd3
  } topk_state_e;
endpackage

// File: rtl/topk_heap_store.sv
module topk_heap_store #(
  parameter int DEPTH = 1024,
  parameter int EW    = 292,
  parameter int NRD   = 3,
  parameter int IW    = $clog2(DEPTH)
) (
  input  logic                     clk_i,
  input  logic                     wr_en_i,
  input  logic [IW-1:0]            wr_idx_i,
  input  logic [EW-1:0]            wr_data_i,
  input  logic [NRD-1:0][IW-1:0]   rd_idx_i,
  output logic [NRD-1:0][EW-1:0]   rd_data_o
);
  logic [EW-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (wr_en_i) mem_q[wr_idx_i] <= wr_data_i;
  end

  for (genvar g = 0; g < NRD; g++) begin : g_rd
    assign rd_data_o[g] = mem_q[rd_idx_i[g]];
  end
endmodule

// File: rtl/topk_sift_step.sv
module topk_sift_step #(
  parameter int SW = 16,
  parameter int IW = 10,
  parameter int CW = 11
) (
  input  logic [IW-1:0] hole_i,
  input  logic [CW-1:0] count_i,
  input  logic [SW-1:0] item_score_i,
  input  logic [SW-1:0] parent_score_i,
  input  logic [SW-1:0] left_score_i,
  input  logic [SW-1:0] right_score_i,
  output logic [IW-1:0] parent_idx_o,
  output logic [IW-1:0] left_idx_o,
  output logic [IW-1:0] right_idx_o,
  output logic          up_done_o,
  output logic          down_done_o,
  output logic          pick_right_o,
  output logic [IW-1:0] child_idx_o
);
  logic [IW+1:0] l_w, r_w, cnt_w;
  logic          has_l, has_r;
  logic [SW-1:0] child_score;

  assign l_w   = ({2'b00, hole_i} << 1) + (IW+2)'(1);
  assign r_w   = l_w + (IW+2)'(1);
  assign cnt_w = (IW+2)'(count_i);
  assign has_l = l_w < cnt_w;
  assign has_r = r_w < cnt_w;

  assign parent_idx_o = (hole_i - IW'(1)) >> 1;
  assign left_idx_o   = l_w[IW-1:0];
  assign right_idx_o  = r_w[IW-1:0];

  // ties stop the walk: equal keys never move
  assign up_done_o    = (hole_i == '0) || (parent_score_i <= item_score_i);
  assign pick_right_o = has_r && (right_score_i < left_score_i);
  assign child_idx_o  = pick_right_o ? right_idx_o : left_idx_o;
  assign child_score  = pick_right_o ? right_score_i : left_score_i;
  assign down_done_o  = !has_l || (child_score >= item_score_i);
endmodule

// File: rtl/topk_feature_filter.sv
module topk_feature_filter
  import topk_pkg::*;
#(
  parameter int CAPACITY = 1024,
  parameter int SCORE_W  = 16,
  parameter int COORD_W  = 10,
  parameter int DESC_W   = 256
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          in_valid_i,
  output logic                          in_ready_o,
  input  logic                          in_last_i,
  input  logic [SCORE_W-1:0]            in_score_i,
  input  logic [COORD_W-1:0]            in_x_i,
  input  logic [COORD_W-1:0]            in_y_i,
  input  logic [DESC_W-1:0]             in_desc_i,
  output logic                          out_valid_o,
  input  logic                          out_ready_i,
  output logic [SCORE_W-1:0]            out_score_o,
  output logic [COORD_W-1:0]            out_x_o,
  output logic [COORD_W-1:0]            out_y_o,
  output logic [DESC_W-1:0]             out_desc_o,
  output logic [$clog2(CAPACITY+1)-1:0] kept_count_o
);
  localparam int IW = $clog2(CAPACITY);
  localparam int CW = $clog2(CAPACITY+1);
  localparam int EW = DESC_W + 2*COORD_W + SCORE_W;
  localparam logic [CW-1:0] CAP_C = CW'(CAPACITY);

  topk_state_e          state_q;
  logic [CW-1:0]        count_q;
  logic [IW-1:0]        hole_q, drain_idx_q;
  logic [EW-1:0]        item_q;
  logic                 last_q;

  logic [2:0][IW-1:0]   rd_idx;
  logic [2:0][EW-1:0]   rd_data;
  logic                 wr_en;
  logic [IW-1:0]        wr_idx;
  logic [EW-1:0]        wr_data;

  logic [IW-1:0]        parent_idx, left_idx, right_idx, child_idx;
  logic                 up_done, down_done, pick_right;
  logic [SCORE_W-1:0]   root_score;
  logic [EW-1:0]        in_entry, child_entry;
  logic                 accept, full, beats_root, drain_end;

  assign in_entry   = {in_desc_i, in_y_i, in_x_i, in_score_i};
  assign in_ready_o = (state_q == ST_IDLE);
  assign accept     = in_valid_i && in_ready_o;
  assign full       = (count_q == CAP_C);
  assign root_score = rd_data[0][SCORE_W-1:0];
  assign beats_root = in_score_i > root_score;

  always_comb begin
    case (state_q)
      ST_UP:    rd_idx[0] = parent_idx;
      ST_DRAIN: rd_idx[0] = drain_idx_q;
      default:  rd_idx[0] = '0;
    endcase
  end
  assign rd_idx[1] = left_idx;
  assign rd_idx[2] = right_idx;

  topk_heap_store #(.DEPTH(CAPACITY), .EW(EW), .NRD(3), .IW(IW)) u_store (
    .clk_i     (clk_i),
    .wr_en_i   (wr_en),
    .wr_idx_i  (wr_idx),
    .wr_data_i (wr_data),
    .rd_idx_i  (rd_idx),
    .rd_data_o (rd_data)
  );

  topk_sift_step #(.SW(SCORE_W), .IW(IW), .CW(CW)) u_step (
    .hole_i         (hole_q),
    .count_i        (count_q),
    .item_score_i   (item_q[SCORE_W-1:0]),
    .parent_score_i (rd_data[0][SCORE_W-1:0]),
    .left_score_i   (rd_data[1][SCORE_W-1:0]),
    .right_score_i  (rd_data[2][SCORE_W-1:0]),
    .parent_idx_o   (parent_idx),
    .left_idx_o     (left_idx),
    .right_idx_o    (right_idx),
    .up_done_o      (up_done),
    .down_done_o    (down_done),
    .pick_right_o   (pick_right),
    .child_idx_o    (child_idx)
  );

  assign child_entry = pick_right ? rd_data[2] : rd_data[1];

  // one write per sift cycle: the moving item rides in item_q, neighbours shift into the hole
  always_comb begin
    wr_en   = 1'b0;
    wr_idx  = hole_q;
    wr_data = item_q;
    if (state_q == ST_UP) begin
      wr_en = 1'b1;
      if (!up_done) wr_data = rd_data[0];
    end else if (state_q == ST_DOWN) begin
      wr_en = 1'b1;
      if (!down_done) wr_data = child_entry;
    end
  end

  assign drain_end = (CW'(drain_idx_q) + CW'(1)) == count_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      count_q     <= '0;
      hole_q      <= '0;
      drain_idx_q <= '0;
      item_q      <= '0;
      last_q      <= 1'b0;
    end else begin
      case (state_q)
        ST_IDLE: if (accept) begin
          last_q <= in_last_i;
          if (!full) begin
            item_q  <= in_entry;
            hole_q  <= count_q[IW-1:0];
            count_q <= count_q + CW'(1);
            state_q <= ST_UP;
          end else if (beats_root) begin
            item_q  <= in_entry;
            hole_q  <= '0;
            state_q <= ST_DOWN;
          end else if (in_last_i) begin
            drain_idx_q <= '0;
            state_q     <= ST_DRAIN;
          end
        end
        ST_UP: begin
          if (up_done) begin
            drain_idx_q <= '0;
            state_q     <= last_q ? ST_DRAIN : ST_IDLE;
          end else begin
            hole_q <= parent_idx;
          end
        end
        ST_DOWN: begin
          if (down_done) begin
            drain_idx_q <= '0;
            state_q     <= last_q ? ST_DRAIN : ST_IDLE;
          end else begin
            hole_q <= child_idx;
          end
        end
        ST_DRAIN: if (out_ready_i) begin
          if (drain_end) begin
            count_q     <= '0;
            drain_idx_q <= '0;
            state_q     <= ST_IDLE;
          end else begin
            drain_idx_q <= drain_idx_q + IW'(1);
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign out_valid_o  = (state_q == ST_DRAIN);
  assign out_score_o  = rd_data[0][SCORE_W-1:0];
  assign out_x_o      = rd_data[0][SCORE_W +: COORD_W];
  assign out_y_o      = rd_data[0][SCORE_W+COORD_W +: COORD_W];
  assign out_desc_o   = rd_data[0][EW-1 -: DESC_W];
  assign kept_count_o = count_q;

  p_count_bound_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    kept_count_o <= CAP_C);

  p_insert_grows_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && in_ready_o && kept_count_o < CAP_C) |=> kept_count_o == $past(kept_count_o) + CW'(1));

  p_full_stays_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (kept_count_o == CAP_C && !out_valid_o) |=> kept_count_o == CAP_C);

  p_drop_keeps_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && in_ready_o && full && !beats_root && !in_last_i) |=> in_ready_o && $stable(kept_count_o));

  p_kept_busy_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && in_ready_o && (!full || beats_root)) |=> !in_ready_o);

  p_drain_closed_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> !in_ready_o);

  p_out_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && !out_ready_i) |=> out_valid_o && $stable(out_score_o) && $stable(out_desc_o)
      && $stable(out_x_o) && $stable(out_y_o));

  p_drain_empty_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && out_ready_i && drain_end) |=> kept_count_o == '0 && in_ready_o);
endmodule

// File: tb/topk_feature_filter_bench.sv
module topk_feature_filter_bench;
  localparam int K  = 8;
  localparam int SW = 16;
  localparam int XW = 10;
  localparam int DW = 256;
  localparam int CW = $clog2(K+1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0, in_last = 1'b0, out_ready = 1'b0;
  logic in_ready, out_valid;
  logic [SW-1:0] in_score, out_score;
  logic [XW-1:0] in_x, in_y, out_x, out_y;
  logic [DW-1:0] in_desc, out_desc;
  logic [CW-1:0] kept;

  int checks = 0, fails = 0;
  int mdl_s [K];
  int mdl_t [K];
  int mdl_n = 0;

  always #10 clk = ~clk;

  topk_feature_filter #(.CAPACITY(K), .SCORE_W(SW), .COORD_W(XW), .DESC_W(DW)) u_topk_feature_filter (
    .clk_i(clk), .rst_ni(rst_n), .in_valid_i(in_valid), .in_ready_o(in_ready), .in_last_i(in_last),
    .in_score_i(in_score), .in_x_i(in_x), .in_y_i(in_y), .in_desc_i(in_desc),
    .out_valid_o(out_valid), .out_ready_i(out_ready), .out_score_o(out_score), .out_x_o(out_x),
    .out_y_o(out_y), .out_desc_o(out_desc), .kept_count_o(kept));

  function automatic logic [XW-1:0] mk_x(int s, int t); return XW'((s*3 + t*11) % 1024); endfunction
  function automatic logic [XW-1:0] mk_y(int s, int t); return XW'((s*7 + t*5) % 1024); endfunction
  function automatic logic [DW-1:0] mk_desc(int s, int t);
    logic [31:0] w;
    w = (32'(s) * 32'd40503) ^ (32'(t) << 20);
    return {8{w}};
  endfunction

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic send(input int s, input int t, input bit last);
    bit kept_it;
    int mi;
    @(negedge clk);
    in_valid = 1'b1; in_last = last; in_score = SW'(s);
    in_x = mk_x(s, t); in_y = mk_y(s, t); in_desc = mk_desc(s, t);
    while (!in_ready) @(negedge clk);
    mi = 0;
    for (int i = 1; i < mdl_n; i++) if (mdl_s[i] < mdl_s[mi]) mi = i;
    kept_it = (mdl_n < K) || (s > mdl_s[mi]);
    if (mdl_n < K) begin mdl_s[mdl_n] = s; mdl_t[mdl_n] = t; mdl_n++; end
    else if (kept_it) begin mdl_s[mi] = s; mdl_t[mi] = t; end
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0; in_last = 1'b0;
    if (!last) begin
      check(in_ready == !kept_it, kept_it ? "R5 ready low while sifting" : "R4 ready kept high on drop",
            longint'(in_ready), longint'(!kept_it));
      check(int'(kept) == mdl_n, mdl_n < K ? "R2 count after arrival" : "R3/R4 count at capacity",
            longint'(kept), longint'(mdl_n));
    end
  endtask

  task automatic drain(input string name, input bit bp);
    int gs [K];
    int got, cyc, exp_n, mins;
    bit stalled, ok, found;
    bit used [K];
    logic [SW-1:0] hs; logic [XW-1:0] hx, hy; logic [DW-1:0] hd;
    got = 0; cyc = 0; exp_n = mdl_n; stalled = 0;
    for (int i = 0; i < K; i++) used[i] = 0;
    while (got < exp_n && cyc < 2000) begin
      @(negedge clk);
      cyc++;
      if (stalled) begin
        check(out_valid && out_score == hs && out_x == hx && out_y == hy && out_desc == hd,
              "R6 output held under backpressure", longint'(out_score), longint'(hs));
        stalled = 0;
      end
      out_ready = bp ? ((cyc % 3) != 0) : 1'b1;
      if (out_valid) begin
        if (out_ready) begin
          gs[got] = int'(out_score);
          found = 0;
          for (int i = 0; i < exp_n; i++)
            if (!found && !used[i] && mdl_s[i] == int'(out_score) && out_x == mk_x(mdl_s[i], mdl_t[i])
                && out_y == mk_y(mdl_s[i], mdl_t[i]) && out_desc == mk_desc(mdl_s[i], mdl_t[i])) begin
              used[i] = 1; found = 1;
            end
          check(found, {"R6 drained entry matches kept payload ", name}, longint'(out_score), -1);
          if (got > 0)
            check(gs[got] >= gs[(got-1)/2], "R7 heap order along drain", longint'(gs[got]),
                  longint'(gs[(got-1)/2]));
          got++;
        end else begin
          stalled = 1; hs = out_score; hx = out_x; hy = out_y; hd = out_desc;
        end
      end
    end
    check(got == exp_n, {"R6 drained count ", name}, longint'(got), longint'(exp_n));
    mins = mdl_s[0];
    for (int i = 1; i < exp_n; i++) if (mdl_s[i] < mins) mins = mdl_s[i];
    check(gs[0] == mins, "R7 first drained is lowest score", longint'(gs[0]), longint'(mins));
    @(negedge clk);
    out_ready = 1'b0;
    ok = !out_valid && kept == '0 && in_ready;
    check(ok, "R8 empty and ready after drain", longint'(kept), 0);
    mdl_n = 0;
  endtask

  task automatic t_reset();
    @(negedge clk);
    check(kept == '0 && !out_valid && in_ready, "R1 reset state", longint'(kept), 0);
  endtask

  task automatic t_partial();
    int sc [5] = '{40, 10, 30, 20, 50};
    for (int i = 0; i < 5; i++) send(sc[i], i, i == 4);
    drain("partial R2", 1'b0);
  endtask

  task automatic t_overflow();
    for (int i = 0; i < 20; i++) send((i*37) % 101 + 1, i, i == 19);
    drain("overflow R3", 1'b0);
  endtask

  task automatic t_ties();
    for (int i = 0; i < K; i++) send(107 - i, i, 1'b0);
    send(100, 9, 1'b0);   // R4 equal to minimum: dropped
    send(50, 10, 1'b0);   // R4 below minimum: dropped
    send(108, 11, 1'b0);  // R3 replaces 100
    send(101, 12, 1'b1);  // R4 equal to new minimum, last: dropped then drain
    drain("ties R4", 1'b0);
  endtask

  task automatic t_backpressure();
    for (int i = 0; i < K; i++) send(200 + ((i*5) % 8), i, i == K-1);
    drain("backpressure R6", 1'b1);
  endtask

  initial begin
    in_score = '0; in_x = '0; in_y = '0; in_desc = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_partial();
    t_overflow();
    t_ties();
    t_backpressure();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #2000000;
    fails++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule